// File: doc/BRIEF.md
# Prescaled Programmable Baud Tick Generator

This block derives the timing enables that a serial transmitter and receiver need, using nothing but one reference clock. The reference is first thinned by a prescaler that passes every cycle or every fourth cycle. A 16-bit divisor then divides the result further, producing the oversampling tick. A second counter divides the oversampling tick by 16 or by 8, selected by a mode input, to give the bit-rate tick. The 8x mode therefore doubles the highest data rate available for a given divisor.

The divisor is loaded one byte at a time through a small write port. A new value is picked up only when the divisor counter next reloads, so the tick stream never contains a shortened or doubled pulse. A divisor of zero stops both ticks. Changing the prescaler select or the mode input restarts all counters, so that the first ticks after the change follow the new setting. Both outputs are one-cycle enables in the reference clock domain. Neither one is a clock.

Top module: `baud_tick_gen`

## Requirements
- R1: With `presc_sel` = 0 the prescaler passes every reference cycle. With `presc_sel` = 1 it passes one cycle in four. The prescale factor P is therefore 1 or 4.
- R2: A write with `wr_en` = 1 stores `wr_data` into the divisor's low byte when `wr_hi` = 0, or into its high byte when `wr_hi` = 1. The new value appears in the divisor register one cycle after the write.
- R3: Reset sets the divisor D to 0x0001 and drives both outputs low. With `presc_sel` = 0, `sample_tick` is then high in every cycle from the first clock edge after reset.
- R4: In steady state, consecutive `sample_tick` pulses are P×D reference cycles apart, for any D from 1 to 65535.
- R5: `bit_tick` pulses once for every N sample ticks, where N = 16 when `os16` = 1 and N = 8 when `os16` = 0. It is high only in a cycle where `sample_tick` is also high, so bit ticks are N×P×D cycles apart.
- R6: A divisor write takes effect at the next reload. The period already in progress keeps the old divisor, and the periods after it use the new one.
- R7: Once the divisor is 0 and the period in progress has ended, no further ticks occur. A later nonzero write restarts the ticks.
- R8: A change of `presc_sel` or `os16` holds both outputs low in the following cycle. If the change is registered at edge E0, the first `sample_tick` follows edge E0+P×D and the first `bit_tick` follows edge E0+N×P×D.
- R9: When P×D > 1, `sample_tick` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Divisor byte write strobe |
| wr_hi | input | 1 | Byte select: 0 selects the low byte, 1 the high byte |
| wr_data | input | 8 | Byte value to write |
| presc_sel | input | 1 | Prescaler select: 0 divides by 1, 1 divides by 4 |
| os16 | input | 1 | Oversampling mode: 1 selects 16x, 0 selects 8x |
| sample_tick | output | 1 | One-cycle oversampling enable |
| bit_tick | output | 1 | One-cycle bit-rate enable |

## Verification
The in-module assertions check, on every cycle, the cycle-level invariants. Each bit tick lands on a sample tick. The counters stay within their limits. The prescaler passes every cycle or has a gap after each enable, as the select requires. Divisor bytes land one cycle after a write. Both outputs go quiet after a configuration change. Pulses do not repeat back to back under the divide-by-4 prescaler. Only the bench's scenarios can show the actual spacing of the ticks. These cover periods across many prescaler, mode and divisor combinations, the alignment of the first ticks after a restart, the deferred effect of a divisor written mid-period, and the stop-and-resume behaviour around a zero divisor.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int DIV_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int PRE_RATE = 4;
    localparam int OVS_HI   = 16;
    localparam int OVS_LO   = 8;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] act;
    } div_state_t;

    typedef struct packed {
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        logic              presc;
        logic              os;
        logic              stick;
        logic              btick;
    } top_state_t;
endpackage

// File: rtl/baud_presc.sv
module baud_presc #(
    parameter int RATE = baud_pkg::PRE_RATE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic clr,
    output logic en
);
    localparam int CW = (RATE > 1) ? $clog2(RATE) : 1;
    localparam logic [CW-1:0] LAST = CW'(RATE - 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        en    = 1'b0;
        if (clr) begin
            cnt_d = '0;
        end else if (!sel) begin
            en    = 1'b1;
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            en    = 1'b1;
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_pass_all_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && !clr) |-> en);
    assert_gap_after_en_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && en && !clr) |=> !en);
endmodule

// File: rtl/baud_div_counter.sv
module baud_div_counter
    import baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    div_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (restart) begin
            st_d.cnt = ONE;
            st_d.act = divisor;
        end else if (en) begin
            if (st_q.act == '0) begin
                st_d.act = divisor;
                st_d.cnt = ONE;
            end else if (st_q.cnt == st_q.act) begin
                tick     = 1'b1;
                st_d.cnt = ONE;
                st_d.act = divisor;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= ONE;
            st_q.act <= ONE;
        end else begin
            st_q <= st_d;
        end
    end

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act != '0) |-> (st_q.cnt != '0 && st_q.cnt <= st_q.act));
    assert_reload_latest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart) |=> (st_q.act == $past(divisor)));
    assert_zero_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act == '0 && $past(st_q.act) == '0) |-> !tick);
endmodule

// File: rtl/baud_bit_counter.sv
module baud_bit_counter #(
    parameter int N_HI = baud_pkg::OVS_HI,
    parameter int N_LO = baud_pkg::OVS_LO
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    input  logic os16,
    output logic btick
);
    localparam int CW = $clog2(N_HI);
    localparam logic [CW-1:0] LAST_HI = CW'(N_HI - 1);
    localparam logic [CW-1:0] LAST_LO = CW'(N_LO - 1);

    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] last;

    always_comb begin
        last  = os16 ? LAST_HI : LAST_LO;
        cnt_d = cnt_q;
        btick = 1'b0;
        if (restart) begin
            cnt_d = '0;
        end else if (tick) begin
            if (cnt_q == last) begin
                btick = 1'b1;
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_lo_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!os16 && !restart && !$past(restart) && $past(!os16)) |-> (cnt_q <= LAST_LO));
    assert_btick_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        btick |-> tick);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              presc_sel,
    input  logic              os16,
    output logic              sample_tick,
    output logic              bit_tick
);
    top_state_t       st_q, st_d;
    logic             cfg_chg;
    logic             pre_en;
    logic             div_tick;
    logic             bt_tick;
    logic [DIV_W-1:0] divisor;

    assign divisor = {st_q.hi, st_q.lo};
    assign cfg_chg = (presc_sel != st_q.presc) || (os16 != st_q.os);

    baud_presc #(.RATE(PRE_RATE)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (presc_sel),
        .clr   (cfg_chg),
        .en    (pre_en)
    );

    baud_div_counter u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (pre_en),
        .restart (cfg_chg),
        .divisor (divisor),
        .tick    (div_tick)
    );

    baud_bit_counter #(.N_HI(OVS_HI), .N_LO(OVS_LO)) u_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (div_tick),
        .restart (cfg_chg),
        .os16    (os16),
        .btick   (bt_tick)
    );

    always_comb begin
        st_d       = st_q;
        st_d.presc = presc_sel;
        st_d.os    = os16;
        st_d.stick = div_tick;
        st_d.btick = bt_tick;
        if (wr_en) begin
            if (wr_hi) st_d.hi = wr_data;
            else       st_d.lo = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lo    <= BYTE_W'(1);
            st_q.hi    <= '0;
            st_q.presc <= 1'b0;
            st_q.os    <= 1'b1;
            st_q.stick <= 1'b0;
            st_q.btick <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample_tick = st_q.stick;
    assign bit_tick    = st_q.btick;

    assert_wr_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hi) |=> (st_q.lo == $past(wr_data)));
    assert_wr_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hi) |=> (st_q.hi == $past(wr_data)));
    assert_bit_on_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> sample_tick);
    assert_quiet_after_chg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> (!sample_tick && !bit_tick));
    assert_no_double_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_tick && presc_sel && st_q.presc) |=> !sample_tick);
endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_hi = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       presc_sel = 1'b0;
    logic       os16 = 1'b1;
    logic       sample_tick;
    logic       bit_tick;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    baud_tick_gen uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi),
        .wr_data(wr_data), .presc_sel(presc_sel), .os16(os16),
        .sample_tick(sample_tick), .bit_tick(bit_tick)
    );

    function automatic int pfac(input bit p);
        return p ? 4 : 1;
    endfunction

    function automatic int nfac(input bit o);
        return o ? 16 : 8;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_byte(input bit hi, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_hi = hi; wr_data = val[7:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_div(input int d);
        wr_byte(1'b0, d & 255);
        wr_byte(1'b1, (d >> 8) & 255);
    endtask

    // force a restart: flip the prescaler for one cycle, then settle on the target
    task automatic restart_cfg(input bit p, input bit o);
        @(negedge clk);
        presc_sel = ~p; os16 = o;
        @(negedge clk);
        presc_sel = p;
    endtask

    task automatic measure(input bit p, input bit o, input int d, input bit full);
        int pd, n, first_s, cyc, scnt, lim;
        bit prev, dbl;
        pd = pfac(p) * d;
        lim = nfac(o) * pd + 50;
        restart_cfg(p, o);
        n = 0; first_s = 0;
        do begin
            @(negedge clk);
            n++;
            if (sample_tick && first_s == 0) first_s = n;
        end while (!(full ? bit_tick : (first_s != 0)) && n < lim);
        check(first_s == pd + 1, "R8 first sample tick", first_s, pd + 1);
        if (full) begin
            check(n == nfac(o) * pd + 1, "R8 first bit tick", n, nfac(o) * pd + 1);
            cyc = 0; scnt = 0; prev = 1'b1; dbl = 1'b0;
            do begin
                @(negedge clk);
                cyc++;
                if (sample_tick) scnt++;
                if (sample_tick && prev) dbl = 1'b1;
                prev = sample_tick;
            end while (!bit_tick && cyc < lim);
            check(cyc == nfac(o) * pd, "R5 bit tick period", cyc, nfac(o) * pd);
            check(scnt == nfac(o), "R5 sample ticks per bit", scnt, nfac(o));
            if (pd > 1) check(!dbl, "R9 no back-to-back sample ticks", dbl, 0);
        end
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!sample_tick && cyc < lim);
        check(cyc == pd, "R4 sample tick period", cyc, pd);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        int seed, m, cnt;
        seed = 17;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check(sample_tick == 1'b0 && bit_tick == 1'b0, "R3 outputs low in reset",
              {sample_tick, bit_tick}, 0);
        rst_n = 1'b1;
        // R3: default divisor 1, prescale 1: tick on every cycle
        cnt = 0;
        repeat (4) begin
            @(negedge clk);
            if (sample_tick) cnt++;
        end
        check(cnt == 4, "R3 reset divisor gives tick every cycle", cnt, 4);
        cnt = 0;
        repeat (32) begin
            @(negedge clk);
            if (bit_tick) cnt++;
        end
        check(cnt == 2, "R3 R5 bit ticks per 32 cycles after reset", cnt, 2);

        // R1 R4: prescale 4 with divisor 1 gives period 4
        measure(1'b1, 1'b1, 1, 1'b1);
        // directed rate points
        set_div(12);  measure(1'b0, 1'b1, 12, 1'b1);
        set_div(2);   measure(1'b1, 1'b1, 2, 1'b1);
        set_div(2);   measure(1'b1, 1'b0, 2, 1'b1);
        // R2 R4: high byte path, divisor 0x0900 with prescale 4
        set_div(16'h0900); measure(1'b1, 1'b1, 16'h0900, 1'b0);
        // R2: both bytes together, 0x0103
        set_div(16'h0103); measure(1'b0, 1'b0, 16'h0103, 1'b0);

        // random mix
        for (int i = 0; i < 14; i++) begin
            int d;
            bit p, o;
            d = 1 + ($urandom % 10);
            p = $urandom % 2;
            o = $urandom % 2;
            set_div(d);
            measure(p, o, d, 1'b1);
        end

        // R6: divisor write mid-period keeps the current period
        set_div(5);
        restart_cfg(1'b0, 1'b1);
        do @(negedge clk); while (!sample_tick);
        wr_en = 1'b1; wr_hi = 1'b0; wr_data = 8'd3;
        m = 0;
        do begin
            @(negedge clk);
            wr_en = 1'b0;
            m++;
        end while (!sample_tick && m < 50);
        check(m == 5, "R6 period in progress keeps old divisor", m, 5);
        m = 0;
        do begin @(negedge clk); m++; end while (!sample_tick && m < 50);
        check(m == 3, "R6 next period uses new divisor", m, 3);

        // R7: zero divisor stops ticks
        set_div(0);
        repeat (20) @(negedge clk);
        cnt = 0;
        repeat (300) begin
            @(negedge clk);
            if (sample_tick || bit_tick) cnt++;
        end
        check(cnt == 0, "R7 zero divisor stops ticks", cnt, 0);
        wr_byte(1'b0, 2);
        cnt = 0;
        repeat (40) begin
            @(negedge clk);
            if (sample_tick) cnt++;
        end
        check(cnt >= 19 && cnt <= 20, "R7 nonzero write resumes ticks", cnt, 20);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule